// File: doc/BRIEF.md
# TS16 Multiframe Alarm Monitor

This block watches time slot 16 of an E1 stream that is already frame aligned. Each strobe brings one TS16 octet and the number of the frame (0 to 15) that it came from within the signalling multiframe. From these octets the block tracks whether the signalling multiframe alignment still holds. It also detects the alarm indication signal carried in time slot 16.

Alignment is judged lost on either of two criteria. The first is a missing alignment pattern in frame 0 of two multiframes in a row. The second is an unbroken run of all-zero TS16 octets. For the alarm indication signal, the block counts zero bits over each multiframe period. The alarm is declared when two periods in a row are nearly free of zeros, and it is withdrawn when a period holds enough zeros.

Both states drive interrupt pulses. A mode input chooses whether the alignment interrupt fires on every change of state or only when alignment is lost. The surrounding receiver supplies the octets and frame numbers. Searching for a new multiframe is left to the surrounding logic.

Top module: `ts16_mf_monitor`

## Requirements
- R1: After reset, `mf_loss` is 1, `ais_state` is 0, and both interrupt outputs are 0.
- R2: A strobed octet with `frame_idx` = 0 is a good alignment pattern when bits 7:4 are all zero and the octet is not 0x00. Such an octet clears `mf_loss` in the cycle after the strobe and restarts the miss count.
- R3: A frame-0 octet that is not a good pattern counts as a miss. A single miss leaves `mf_loss` unchanged. Two consecutive frame-0 misses set `mf_loss` in the cycle after the second miss.
- R4: Sixteen consecutive strobed octets equal to 0x00, at any frame numbers, set `mf_loss` in the cycle after the sixteenth. Any nonzero octet restarts that run, so 15 zero octets followed by a nonzero one do not set it.
- R5: A period runs from the octet strobed with `frame_idx` = 0 to the octet strobed with `frame_idx` = 15, and it holds 128 bits. `ais_state` rises in the cycle after a frame-15 strobe when that period and the complete period before it each held fewer than 4 zero bits. A qualifying period that does not directly follow another qualifying period does not raise it.
- R6: A completed period that holds 4 or more zero bits clears `ais_state` in the cycle after its frame-15 strobe.
- R7: `irq_ais` is high for exactly the one cycle in which `ais_state` shows a new value. This holds for both a rise and a fall.
- R8: With `cos_mode` = 1, `irq_mf` is high for the one cycle in which `mf_loss` shows a new value, in either direction.
- R9: With `cos_mode` = 0, `irq_mf` pulses only in the cycle in which `mf_loss` rises. A fall produces no pulse.
- R10: While `ts_valid` is 0, `ts_octet` and `frame_idx` have no effect: both states hold and no interrupt fires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ts_valid | input | 1 | Strobe: `ts_octet` and `frame_idx` are valid this cycle |
| ts_octet | input | 8 | Recovered TS16 octet |
| frame_idx | input | 4 | Frame number within the 16-frame multiframe |
| cos_mode | input | 1 | 1: alignment interrupt on every change; 0: only on loss |
| mf_loss | output | 1 | Multiframe alignment lost |
| ais_state | output | 1 | TS16 alarm indication signal present |
| irq_mf | output | 1 | Alignment interrupt pulse |
| irq_ais | output | 1 | Alarm state change pulse |

## Verification
The assertions assume three things about the inputs. Frame numbers reach the block in ascending order. Each frame-0 strobe opens a period, and the frame-15 strobe of that period closes it. `cos_mode` changes only while `mf_loss` is steady. The stimulus sends whole multiframes through one task, which counts frame numbers upward from 0. Where a scenario needs a zero run that starts mid-multiframe, the bench still sends those frames with rising numbers. The bench sets `cos_mode` only between scenarios, while the stream is idle.

// File: rtl/ts16_mon_pkg.sv
// Package: shared constants and helpers for the TS16 multiframe alarm monitor.
// Assumes an 8-bit time slot octet; everything else is parameterised per module.
package ts16_mon_pkg;

    localparam int OCTET_W = 8;
    localparam int ZCNT_W  = $clog2(OCTET_W + 1);

    typedef logic [OCTET_W-1:0] octet_t;
    typedef logic [ZCNT_W-1:0]  zcnt_t;

    // Number of zero bits in one octet.
    function automatic zcnt_t count_zeros(input octet_t o);
        zcnt_t n;
        n = '0;
        for (int b = 0; b < OCTET_W; b++) begin
            if (!o[b]) n = n + zcnt_t'(1);
        end
        return n;
    endfunction

endpackage

// File: rtl/ts16_mf_align.sv
// Module: tracks TS16 multiframe alignment using two independent loss criteria:
// repeated missing pattern in frame 0, and a long run of all-zero octets.
// Assumes octets arrive already frame aligned with a correct frame number.
// Restoration happens on a single good frame-0 pattern.
module ts16_mf_align
    import ts16_mon_pkg::*;
#(
    parameter int MF_FRAMES    = 16,
    parameter int MISS_LIMIT   = 2,
    parameter int ZERO_RUN_LEN = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ts_valid,
    input  octet_t                       ts_octet,
    input  logic [$clog2(MF_FRAMES)-1:0] frame_idx,
    output logic                         mf_loss
);

    localparam int FIDX_W = $clog2(MF_FRAMES);
    localparam int MISS_W = $clog2(MISS_LIMIT + 1);
    localparam int RUN_W  = $clog2(ZERO_RUN_LEN + 1);

    logic [MISS_W-1:0] miss_cnt;
    logic [RUN_W-1:0]  run_cnt;
    logic              at_frame0;
    logic              all_zero;
    logic              pattern_ok;
    logic              miss_hit;
    logic              run_hit;

    // Decode of the current strobe: frame position, pattern and zero content.
    always_comb begin
        at_frame0  = ts_valid && (frame_idx == FIDX_W'(0));
        all_zero   = (ts_octet == '0);
        pattern_ok = (ts_octet[OCTET_W-1:OCTET_W-4] == 4'b0000) && !all_zero;
        miss_hit   = at_frame0 && !pattern_ok && (miss_cnt == MISS_W'(MISS_LIMIT - 1));
        run_hit    = ts_valid && all_zero && (run_cnt == RUN_W'(ZERO_RUN_LEN - 1));
    end

    // Counts consecutive frame-0 pattern misses, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            miss_cnt <= '0;
        end else if (at_frame0) begin
            if (pattern_ok)
                miss_cnt <= '0;
            else if (miss_cnt != MISS_W'(MISS_LIMIT))
                miss_cnt <= miss_cnt + MISS_W'(1);
        end
    end

    // Counts consecutive all-zero octets, saturating at the run length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (ts_valid) begin
            if (!all_zero)
                run_cnt <= '0;
            else if (run_cnt != RUN_W'(ZERO_RUN_LEN))
                run_cnt <= run_cnt + RUN_W'(1);
        end
    end

    // Alignment state: set by either loss criterion, cleared by a good pattern.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mf_loss <= 1'b1;
        else if (miss_hit || run_hit)
            mf_loss <= 1'b1;
        else if (at_frame0 && pattern_ok)
            mf_loss <= 1'b0;
    end

    // R3
    loss_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mf_loss) |-> $past(ts_valid))
        else $error("mf_loss rose without a strobe");

    // R2
    restore_at_frame0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mf_loss) |-> $past(ts_valid && frame_idx == FIDX_W'(0)))
        else $error("alignment restored outside frame 0");

    // R4
    run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= RUN_W'(ZERO_RUN_LEN))
        else $error("zero run counter overflowed");

    // R3
    miss_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_cnt <= MISS_W'(MISS_LIMIT))
        else $error("miss counter overflowed");

endmodule

// File: rtl/ts16_ais_detect.sv
// Module: detects the TS16 alarm indication signal by counting zero bits over
// each multiframe period (frame 0 to the last frame). Too few zeros in enough
// consecutive periods sets the alarm; one period with enough zeros clears it.
// Assumes frame numbers ascend; a period only counts if its frame 0 was seen.
module ts16_ais_detect
    import ts16_mon_pkg::*;
#(
    parameter int MF_FRAMES    = 16,
    parameter int AIS_ZERO_MIN = 4,
    parameter int AIS_PERIODS  = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ts_valid,
    input  octet_t                       ts_octet,
    input  logic [$clog2(MF_FRAMES)-1:0] frame_idx,
    output logic                         ais_state
);

    localparam int FIDX_W   = $clog2(MF_FRAMES);
    localparam int ACC_W    = $clog2(MF_FRAMES * OCTET_W + 1);
    localparam int STREAK_W = $clog2(AIS_PERIODS + 1);

    logic [ACC_W-1:0]    zero_acc;
    logic [ACC_W-1:0]    acc_next;
    logic [STREAK_W-1:0] streak;
    logic [STREAK_W-1:0] streak_next;
    logic                period_open;
    logic                is_first;
    logic                is_last;
    logic                period_low;

    // Running zero total for the period and the verdict at its last frame.
    always_comb begin
        is_first    = (frame_idx == FIDX_W'(0));
        is_last     = (frame_idx == FIDX_W'(MF_FRAMES - 1));
        acc_next    = is_first ? ACC_W'(count_zeros(ts_octet))
                               : zero_acc + ACC_W'(count_zeros(ts_octet));
        period_low  = (acc_next < ACC_W'(AIS_ZERO_MIN));
        streak_next = (streak == STREAK_W'(AIS_PERIODS)) ? streak
                                                         : streak + STREAK_W'(1);
    end

    // Accumulates zeros and tracks whether a period started at frame 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zero_acc    <= '0;
            period_open <= 1'b0;
        end else if (ts_valid) begin
            zero_acc <= acc_next;
            if (is_first)
                period_open <= 1'b1;
            else if (is_last)
                period_open <= 1'b0;
        end
    end

    // Closes a complete period: updates the low-period streak and alarm state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            streak    <= '0;
            ais_state <= 1'b0;
        end else if (ts_valid && is_last && (period_open || is_first)) begin
            if (period_low) begin
                streak <= streak_next;
                if (streak_next == STREAK_W'(AIS_PERIODS))
                    ais_state <= 1'b1;
            end else begin
                streak    <= '0;
                ais_state <= 1'b0;
            end
        end
    end

    // R5
    ais_set_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ais_state) |-> $past(ts_valid && frame_idx == FIDX_W'(MF_FRAMES - 1)))
        else $error("ais rose outside a period end");

    // R6
    ais_clear_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ais_state) |-> $past(ts_valid && frame_idx == FIDX_W'(MF_FRAMES - 1)))
        else $error("ais fell outside a period end");

    // R5
    streak_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        streak <= STREAK_W'(AIS_PERIODS))
        else $error("streak counter overflowed");

endmodule

// File: rtl/ts16_irq_gen.sv
// Module: turns the alignment and alarm states into one-cycle interrupt pulses.
// Pulses are high in the first cycle a state shows its new value. Assumes
// both states are registered upstream and reset to the values given here.
module ts16_irq_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic cos_mode,
    input  logic mf_loss,
    input  logic ais_state,
    output logic irq_mf,
    output logic irq_ais
);

    logic mf_prev;
    logic ais_prev;

    // Remembers last cycle's states, matching their reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mf_prev  <= 1'b1;
            ais_prev <= 1'b0;
        end else begin
            mf_prev  <= mf_loss;
            ais_prev <= ais_state;
        end
    end

    // Edge detection; the mode decides whether a fall of mf_loss counts.
    always_comb begin
        irq_ais = (ais_state != ais_prev);
        irq_mf  = cos_mode ? (mf_loss != mf_prev) : (mf_loss && !mf_prev);
    end

    // R7
    irq_ais_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ais |=> !irq_ais || (ais_state != $past(ais_state)))
        else $error("irq_ais held without a new change");

endmodule

// File: rtl/ts16_mf_monitor.sv
// Module: top of the TS16 multiframe alarm monitor. Joins the alignment
// tracker, alarm detector and interrupt generator. Assumes an aligned E1
// stream delivering one TS16 octet per frame with its multiframe frame number.
module ts16_mf_monitor
    import ts16_mon_pkg::*;
#(
    parameter int MF_FRAMES    = 16,
    parameter int MISS_LIMIT   = 2,
    parameter int ZERO_RUN_LEN = 16,
    parameter int AIS_ZERO_MIN = 4,
    parameter int AIS_PERIODS  = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ts_valid,
    input  logic [7:0]                   ts_octet,
    input  logic [$clog2(MF_FRAMES)-1:0] frame_idx,
    input  logic                         cos_mode,
    output logic                         mf_loss,
    output logic                         ais_state,
    output logic                         irq_mf,
    output logic                         irq_ais
);

    ts16_mf_align #(
        .MF_FRAMES   (MF_FRAMES),
        .MISS_LIMIT  (MISS_LIMIT),
        .ZERO_RUN_LEN(ZERO_RUN_LEN)
    ) u_align (
        .clk      (clk),
        .rst_n    (rst_n),
        .ts_valid (ts_valid),
        .ts_octet (ts_octet),
        .frame_idx(frame_idx),
        .mf_loss  (mf_loss)
    );

    ts16_ais_detect #(
        .MF_FRAMES   (MF_FRAMES),
        .AIS_ZERO_MIN(AIS_ZERO_MIN),
        .AIS_PERIODS (AIS_PERIODS)
    ) u_ais (
        .clk      (clk),
        .rst_n    (rst_n),
        .ts_valid (ts_valid),
        .ts_octet (ts_octet),
        .frame_idx(frame_idx),
        .ais_state(ais_state)
    );

    ts16_irq_gen u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cos_mode (cos_mode),
        .mf_loss  (mf_loss),
        .ais_state(ais_state),
        .irq_mf   (irq_mf),
        .irq_ais  (irq_ais)
    );

    // R7
    ais_change_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ais_state != $past(ais_state)) |-> irq_ais)
        else $error("ais change without interrupt");

    // R9
    no_irq_on_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cos_mode && $fell(mf_loss)) |-> !irq_mf)
        else $error("restore interrupt in loss-only mode");

    // R8
    cos_change_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cos_mode && (mf_loss != $past(mf_loss))) |-> irq_mf)
        else $error("alignment change without interrupt");

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ts_valid) |-> ($stable(mf_loss) && $stable(ais_state)))
        else $error("state moved without a strobe");

endmodule

// File: tb/test_ts16_mf_monitor.sv
module test_ts16_mf_monitor;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ts_valid = 1'b0;
    logic [7:0] ts_octet = 8'h00;
    logic [3:0] frame_idx = 4'd0;
    logic       cos_mode = 1'b0;
    logic       mf_loss;
    logic       ais_state;
    logic       irq_mf;
    logic       irq_ais;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ts16_mf_monitor i_ts16_mf_monitor (
        .clk      (clk),
        .rst_n    (rst_n),
        .ts_valid (ts_valid),
        .ts_octet (ts_octet),
        .frame_idx(frame_idx),
        .cos_mode (cos_mode),
        .mf_loss  (mf_loss),
        .ais_state(ais_state),
        .irq_mf   (irq_mf),
        .irq_ais  (irq_ais)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // One strobe, called at a falling edge; returns one falling edge later.
    task automatic send(input logic [7:0] o, input logic [3:0] f);
        ts_valid  = 1'b1;
        ts_octet  = o;
        frame_idx = f;
        @(negedge clk);
        ts_valid  = 1'b0;
    endtask

    task automatic send_rest(input logic [7:0] o);
        for (int f = 1; f < 16; f++) send(o, 4'(f));
    endtask

    task automatic t_reset;
        check("R1", "mf_loss", mf_loss, 1'b1);
        check("R1", "ais_state", ais_state, 1'b0);
        check("R1", "irq_mf", irq_mf, 1'b0);
        check("R1", "irq_ais", irq_ais, 1'b0);
    endtask

    task automatic t_align;
        cos_mode = 1'b0;
        send(8'h0B, 4'd0);
        check("R2", "mf_loss after good pattern", mf_loss, 1'b0);
        check("R9", "irq_mf on restore, loss-only", irq_mf, 1'b0);
    endtask

    task automatic t_miss_and_ais;
        send(8'hFF, 4'd0);
        check("R3", "mf_loss after one miss", mf_loss, 1'b0);
        send_rest(8'hFF);
        check("R5", "ais after one low period", ais_state, 1'b0);
        send(8'hFF, 4'd0);
        check("R3", "mf_loss after two misses", mf_loss, 1'b1);
        check("R9", "irq_mf on loss", irq_mf, 1'b1);
        send_rest(8'hFF);
        check("R5", "ais after two low periods", ais_state, 1'b1);
        check("R7", "irq_ais on rise", irq_ais, 1'b1);
        @(negedge clk);
        check("R7", "irq_ais one cycle", irq_ais, 1'b0);
    endtask

    task automatic t_restore_clear;
        send(8'h0B, 4'd0);
        check("R2", "mf_loss restored", mf_loss, 1'b0);
        check("R9", "no irq_mf on fall", irq_mf, 1'b0);
        send_rest(8'hFF);
        check("R6", "ais cleared by 5-zero period", ais_state, 1'b0);
        check("R7", "irq_ais on fall", irq_ais, 1'b1);
    endtask

    task automatic t_streak_break;
        send(8'hFF, 4'd0); send_rest(8'hFF);
        send(8'h0B, 4'd0); send_rest(8'hFF);
        send(8'hFF, 4'd0); send_rest(8'hFF);
        check("R5", "ais after broken streak", ais_state, 1'b0);
        send(8'hFF, 4'd0); send_rest(8'hFF);
        check("R5", "ais after consecutive lows", ais_state, 1'b1);
        send(8'h0B, 4'd0); send_rest(8'hFF);
        check("R6", "ais cleared again", ais_state, 1'b0);
        check("R2", "aligned after good pattern", mf_loss, 1'b0);
    endtask

    task automatic t_idle;
        ts_octet  = 8'h00;
        frame_idx = 4'd0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (irq_mf || irq_ais) check("R10", "irq while idle", 1'b1, 1'b0);
        end
        check("R10", "mf_loss while idle", mf_loss, 1'b0);
        check("R10", "ais while idle", ais_state, 1'b0);
        check("R10", "irq_mf while idle", irq_mf, 1'b0);
    endtask

    task automatic t_zero_run;
        cos_mode = 1'b1;
        send_rest(8'h00);
        check("R4", "mf_loss after 15 zeros", mf_loss, 1'b0);
        send(8'h0B, 4'd0);
        check("R4", "mf_loss after run broken", mf_loss, 1'b0);
        send_rest(8'h00);
        check("R4", "mf_loss after 15 more zeros", mf_loss, 1'b0);
        send(8'h00, 4'd0);
        check("R4", "mf_loss after 16 zeros", mf_loss, 1'b1);
        check("R8", "irq_mf on loss, change mode", irq_mf, 1'b1);
        send(8'h0B, 4'd0);
        check("R2", "restored after zero run", mf_loss, 1'b0);
        check("R8", "irq_mf on restore, change mode", irq_mf, 1'b1);
        @(negedge clk);
        check("R8", "irq_mf one cycle", irq_mf, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_align();
        t_miss_and_ais();
        t_restore_clear();
        t_streak_break();
        t_idle();
        t_zero_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule